// File: doc/BRIEF.md
# Horizontal Line Timing Generator

This block derives every per-line horizontal timing signal from a pixel clock that runs at the colour-subcarrier rate. A free-running position counter steps once per pixel clock through a fixed line period. Decodes of that count give the horizontal blank window, the horizontal sync and colour-burst windows inside it, a one-cycle pulse at the start of each line, and an enable for the visible pixel clocks. The same pixel clock is divided by three to make the phase clock for the processor.

Software controls vertical timing with a one-bit register that it writes directly. The block merges that bit with horizontal sync into composite sync. A second write strobe sets a stall latch that pulls the processor ready line low. Hardware clears the latch when the next line begins, which lets a program whose loops vary in length lock itself to the raster.

Top module: `hline_timing_gen`

## Requirements
- R1: After reset the position counter starts at 0 and steps by one each pixel clock through 0..227, then wraps to 0. `line_start` is high exactly in the cycles where the count is 0.
- R2: `hblank` is high for counts 0 to 67. `pix_en` is its complement, high for the 160 counts 68 to 227.
- R3: Horizontal sync is active (high) for counts 16 to 31. With the vertical sync bit at 0, `csync` equals horizontal sync.
- R4: `burst` is high for counts 36 to 51 and low on every other count.
- R5: `cpu_clk` is high in one pixel cycle of every three. It is high in the first cycle after reset and then follows the pattern low, low, high.
- R6: A pixel-clock cycle with `wr_wsync` high drives `rdy` low from the next cycle on.
- R7: Once stalled, `rdy` stays low until the counter wraps. It is high again in the cycle where the count is 0, and `line_start` is high in that same cycle.
- R8: A `wr_wsync` write in the cycle at count 227 takes priority over the wrap. `rdy` then stays low through the whole following line and rises at the wrap after that.
- R9: A cycle with `wr_vsync` high loads `wr_data` bit 1 into the vertical sync bit. The other data bits are ignored. `csync` is horizontal sync XOR vertical sync, so the horizontal pulses are inverted while vertical sync is 1.
- R10: In reset the count is 0, `rdy` is high, the vertical sync bit is 0 and `cpu_clk` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_wsync | input | 1 | Write strobe that sets the stall latch |
| wr_vsync | input | 1 | Write strobe for the vertical sync bit |
| wr_data | input | 8 | Write data bus; bit 1 is the vertical sync value |
| cpu_clk | output | 1 | Pixel clock divided by three, high one cycle in three |
| rdy | output | 1 | Processor ready; low while the stall latch is set |
| hblank | output | 1 | Horizontal blank window |
| csync | output | 1 | Composite sync, horizontal XOR vertical |
| burst | output | 1 | Colour-burst window |
| line_start | output | 1 | One-cycle pulse at count 0 |
| pix_en | output | 1 | High on the 160 visible pixel clocks |

## Verification
Every window output is decoded from the position counter. A skipped or repeated count therefore moves the edges of `hblank`, `csync` and `burst` away from their fixed counts, and this shows within one line of 228 cycles. A stall latch that clears at the wrong time shows as `rdy` rising early, late or at a count other than 0. A write at count 227 is the case that tells write priority apart from release priority. A divider phase error shows within three cycles of reset as `cpu_clk` high in the wrong cycle.

// File: rtl/hline_pkg.sv
package hline_pkg;
   // one-bit state of the processor stall latch
   typedef enum logic {
      RUN   = 1'b0,
      STALL = 1'b1
   } stall_e;
endpackage

// File: rtl/hline_counter.sv
module hline_counter #(
   parameter int LINE_COUNTS = 228,
   localparam int CW = $clog2(LINE_COUNTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt,
   output logic          last
);
   localparam logic [CW-1:0] LAST = CW'(LINE_COUNTS - 1);

   assign last = (cnt == LAST);

   generate
      if (LINE_COUNTS == (1 << CW)) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)    cnt <= '0;
            else if (last) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> cnt == $past(cnt) + 1'b1);
   a_r1_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> cnt == '0);
endmodule

// File: rtl/hline_window.sv
module hline_window #(
   parameter int CW    = 8,
   parameter int START = 16,
   parameter int LEN   = 16
) (
   input  logic [CW-1:0] cnt,
   output logic          hit
);
   localparam logic [CW-1:0] LO = CW'(START);
   localparam logic [CW-1:0] HI = CW'(START + LEN - 1);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("hline_window: LEN must be at least 1");
      end
      if (LEN == 1) begin : g_point
         assign hit = (cnt == LO);
      end else if (START == 0) begin : g_from_zero
         assign hit = (cnt <= HI);
      end else begin : g_range
         assign hit = (cnt >= LO) && (cnt <= HI);
      end
   endgenerate
endmodule

// File: rtl/hline_clkdiv.sv
module hline_clkdiv #(
   parameter int DIV = 3,
   localparam int DW = (DIV > 2) ? $clog2(DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam logic [DW-1:0] TOP = DW'(DIV - 1);
   logic [DW-1:0] phase;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("hline_clkdiv: DIV must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)           phase <= '0;
      else if (phase == TOP) phase <= '0;
      else                   phase <= phase + 1'b1;
   end

   assign tick = (phase == '0);

   a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   a_r5_tick_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == TOP) |=> tick);
endmodule

// File: rtl/hline_stall_latch.sv
module hline_stall_latch
   import hline_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic release_i,
   output logic rdy
);
   stall_e state;

   always_ff @(posedge clk) begin
      if (!rst_n)         state <= RUN;
      else if (set)       state <= STALL;
      else if (release_i) state <= RUN;
   end

   assign rdy = (state == RUN);

   a_r6_stall_next: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> !rdy);
   a_r7_release_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !set) |=> rdy);
   a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && !release_i) |=> !rdy);
endmodule

// File: rtl/hline_timing_gen.sv
module hline_timing_gen #(
   parameter int LINE_COUNTS = 228,
   parameter int BLANK_COUNTS = 68,
   parameter int SYNC_START = 16,
   parameter int SYNC_LEN = 16,
   parameter int BURST_START = 36,
   parameter int BURST_LEN = 16,
   parameter int CPU_DIV = 3,
   parameter int DATA_W = 8,
   parameter int VSYNC_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_wsync,
   input  logic              wr_vsync,
   input  logic [DATA_W-1:0] wr_data,
   output logic              cpu_clk,
   output logic              rdy,
   output logic              hblank,
   output logic              csync,
   output logic              burst,
   output logic              line_start,
   output logic              pix_en
);
   localparam int CW = $clog2(LINE_COUNTS);
   localparam logic [CW-1:0] BLANK_END = CW'(BLANK_COUNTS);

   generate
      if (BLANK_COUNTS >= LINE_COUNTS) begin : g_bad_blank
         $error("hline_timing_gen: blank must be shorter than the line");
      end
      if (SYNC_START + SYNC_LEN > BLANK_COUNTS) begin : g_bad_sync
         $error("hline_timing_gen: sync window must sit inside blank");
      end
      if (BURST_START + BURST_LEN > BLANK_COUNTS) begin : g_bad_burst
         $error("hline_timing_gen: burst window must sit inside blank");
      end
      if (VSYNC_BIT >= DATA_W) begin : g_bad_bit
         $error("hline_timing_gen: VSYNC_BIT outside data bus");
      end
   endgenerate

   logic [CW-1:0] hcount;
   logic          line_last;
   logic          hsync;
   logic          vsync_q;

   hline_counter #(.LINE_COUNTS(LINE_COUNTS)) u_count (
      .clk  (clk),
      .rst_n(rst_n),
      .cnt  (hcount),
      .last (line_last)
   );

   hline_window #(.CW(CW), .START(SYNC_START), .LEN(SYNC_LEN)) u_sync (
      .cnt(hcount),
      .hit(hsync)
   );

   hline_window #(.CW(CW), .START(BURST_START), .LEN(BURST_LEN)) u_burst (
      .cnt(hcount),
      .hit(burst)
   );

   hline_clkdiv #(.DIV(CPU_DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (cpu_clk)
   );

   hline_stall_latch u_stall (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (wr_wsync),
      .release_i(line_last),
      .rdy      (rdy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        vsync_q <= 1'b0;
      else if (wr_vsync) vsync_q <= wr_data[VSYNC_BIT];
   end

   assign hblank     = (hcount < BLANK_END);
   assign pix_en     = !hblank;
   assign line_start = (hcount == '0);
   assign csync      = hsync ^ vsync_q;

   a_r3_sync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |-> hblank);
   a_r4_burst_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      burst |-> hblank);
   a_r4_burst_sync_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(burst && hsync));
   a_r7_rdy_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> line_start);
   a_r9_vsync_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vsync |=> $stable(vsync_q));
endmodule

// File: tb/hline_timing_gen_test.sv
module hline_timing_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_wsync = 1'b0;
   logic       wr_vsync = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic cpu_clk, rdy, hblank, csync, burst, line_start, pix_en;

   int checks = 0;
   int fails = 0;
   int pos = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hline_timing_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_wsync(wr_wsync), .wr_vsync(wr_vsync),
      .wr_data(wr_data), .cpu_clk(cpu_clk), .rdy(rdy), .hblank(hblank),
      .csync(csync), .burst(burst), .line_start(line_start), .pix_en(pix_en)
   );

   // {count, hblank, csync(vsync=0), burst, pix_en, line_start}
   localparam int NV = 13;
   localparam logic [12:0] VEC [NV] = '{
      {8'd0,   5'b10001}, {8'd15,  5'b10000}, {8'd16,  5'b11000},
      {8'd31,  5'b11000}, {8'd32,  5'b10000}, {8'd35,  5'b10000},
      {8'd36,  5'b10100}, {8'd51,  5'b10100}, {8'd52,  5'b10000},
      {8'd67,  5'b10000}, {8'd68,  5'b00010}, {8'd150, 5'b00010},
      {8'd227, 5'b00010}
   };

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at count %0d: actual %h expected %h", req, pos, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      pos = (pos + 1) % 228;
   endtask

   task automatic step_to(int target);
      while (pos != target) step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pos = 0;
      // R10 reset state
      check("R10", {4'd0, cpu_clk, rdy, csync, line_start}, 8'b0000_1101);
      // R5 divider pattern
      for (int i = 1; i <= 6; i++) begin
         step();
         check("R5", {7'd0, cpu_clk}, {7'd0, (i % 3) == 0});
      end
      // R1..R4 window table
      for (int v = 0; v < NV; v++) begin
         step_to(int'(VEC[v][12:5]));
         check("R1/R2/R3/R4 r1_", {3'd0, hblank, csync, burst, pix_en, line_start},
               {3'd0, VEC[v][4:0]});
         check("R2", {7'd0, pix_en}, {7'd0, !VEC[v][4]});
      end
      // R9 vertical sync inverts horizontal pulses
      wr_vsync = 1'b1; wr_data = 8'h02;
      step();
      wr_vsync = 1'b0; wr_data = 8'h00;
      step_to(20);
      check("R9 in sync", {7'd0, csync}, 8'd0);
      step_to(40);
      check("R9 out of sync", {7'd0, csync}, 8'd1);
      wr_vsync = 1'b1; wr_data = 8'hFD;
      step();
      wr_vsync = 1'b0; wr_data = 8'h00;
      step_to(20);
      check("R9 cleared by bit 1", {7'd0, csync}, 8'd1);
      step_to(40);
      check("R9 cleared outside", {7'd0, csync}, 8'd0);
      // R6/R7 stall and release
      step_to(100);
      wr_wsync = 1'b1;
      step();
      wr_wsync = 1'b0;
      check("R6", {7'd0, rdy}, 8'd0);
      step_to(227);
      check("R7 held", {7'd0, rdy}, 8'd0);
      step();
      check("R7 release", {6'd0, rdy, line_start}, 8'b11);
      // R8 write on last count
      step_to(227);
      wr_wsync = 1'b1;
      step();
      wr_wsync = 1'b0;
      check("R8 start of line", {6'd0, rdy, line_start}, 8'b01);
      step_to(227);
      check("R8 end of line", {7'd0, rdy}, 8'd0);
      step();
      check("R8 release", {6'd0, rdy, line_start}, 8'b11);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule